// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block is the slave side of a three-wire control port. A host frames each transfer with an active-low load strobe and moves bits on a serial clock over one data line. Each frame carries a direction flag, a three-bit register address and nine data bits, most significant first. A write frame updates one of three control registers when the strobe is released. A read frame makes the block drive the addressed register back onto the data line for the host. The data line is split into an input, an output and an output enable, so that a pad cell at the chip edge can merge them.

The three registers feed the rest of the chip as decoded fields. The configuration register holds the sampling mode, the clamp bias select, power-down, output delay and single-byte output. The gain register holds a six-bit straight-binary code. The offset register holds a nine-bit sign-magnitude value. All serial inputs are synchronised into the system clock domain, so the serial clock must be well below half the system clock. At a 125 MHz system clock a 10 MHz serial clock fits.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset the fields read: sampling mode 1 (correlated double sampling), clamp bias select 1, power-down 0, output delay 0, single-byte output 0, gain code 0 and offset 0.
- R2: A frame is 13 bits sampled on serial clock rising edges while ld_n is low. The first bit is the direction flag (0 write, 1 read), then address bits 2..0, then data bits 8..0. A write takes effect after ld_n returns high.
- R3: Address 0 is the configuration register. Data bit 4 is the sampling mode, bit 3 the clamp bias select, bit 2 power-down, bit 1 output delay and bit 0 single-byte output. Each bit drives its output port directly.
- R4: Address 3 is the gain register. Data bits 5..0 become gain_code.
- R5: Address 6 is the offset register. All nine data bits become offset_sm unchanged. Bit 8 is the sign and bits 7..0 the magnitude.
- R6: On a read frame, data bits 8..0 of the addressed register are driven on sdio_out. The bits change on the serial clock falling edges, starting with the falling edge that follows the fourth rising edge, so the host samples them on rising edges 5 to 13. sdio_oe is high only from that first falling edge until ld_n returns high, and only in read frames.
- R7: Bits that are fixed in a register are not stored. They read back at their fixed values: bits 8..5 of the configuration register read 0011, and bits 8..6 of the gain register read 000. Values written there have no effect.
- R8: A frame whose strobe closes after fewer or more than 13 rising edges changes no register.
- R9: A write to any address other than 0, 3 or 6 changes no register, and a read from such an address returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial read data towards the host |
| sdio_oe | output | 1 | High while the block drives the data line |
| cds_mode | output | 1 | Sampling mode, 1 = correlated double sampling, 0 = sample-and-hold |
| clamp_hi | output | 1 | Clamp bias level select, 1 = upper level |
| pwr_down | output | 1 | Power-down request |
| out_delay | output | 1 | Output delay enable |
| one_byte | output | 1 | Single-byte (high byte only) output enable |
| gain_code | output | 6 | Gain code, straight binary |
| offset_sm | output | 9 | Offset, sign-magnitude, bit 8 is the sign |

## Verification
The gain register is swept over all 64 codes and the configuration register over all 32 field combinations. Each value is written, then checked both at the ports and through a read frame. This separates field placement from the read path. A stride through the offset codes, including both signs and the extreme magnitudes, shows that the nine bits are carried without any conversion. Writes with all ones in the fixed bit positions, short and long frames, and writes and reads at every reserved address follow. Each of these is judged by the unchanged port values and by the read-back word, and the output enable is observed in every frame.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 9;
   localparam int GAIN_W = 6;
   localparam int CFG_W = 5;

   localparam logic [ADDR_W-1:0] ADR_CFG = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_GAIN = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_OFS = 3'd6;

   localparam logic [DATA_W-CFG_W-1:0] CFG_FIXED = 4'b0011;

   typedef struct packed {
      logic cds;
      logic clamp_hi;
      logic pwr_down;
      logic out_dly;
      logic one_byte;
   } cfg_t;

   localparam cfg_t CFG_RST = '{cds: 1'b1, clamp_hi: 1'b1, pwr_down: 1'b0,
                                out_dly: 1'b0, one_byte: 1'b0};
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ser_ctl_sync needs at least two stages");
      end
      if (W < 1) begin : g_badw
         $error("ser_ctl_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_st
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[i] <= RST_VAL;
               else        st[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[i] <= RST_VAL;
               else        st[i] <= st[i-1];
            end
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/ser_ctl_frame.sv
module ser_ctl_frame #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              ld_n_s,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              cmt_vld,
   output logic [ADDR_W-1:0] cmt_addr,
   output logic [DATA_W-1:0] cmt_data
);
   localparam int HDR = 1 + ADDR_W;
   localparam int FRAME = HDR + DATA_W;
   localparam int CNT_W = $clog2(FRAME + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME + 1);
   localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR);
   localparam logic [CNT_W-1:0] CNT_FRM = CNT_W'(FRAME);

   generate
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad
         $error("ser_ctl_frame field widths too small");
      end
   endgenerate

   logic sclk_d, ld_d;
   logic rise, fall, start, stop, active;
   logic [CNT_W-1:0] cnt;
   logic [FRAME-1:0] shreg;
   logic rd_on;
   logic [DATA_W-1:0] out_sh;

   assign rise   = sclk_s & ~sclk_d;
   assign fall   = ~sclk_s & sclk_d;
   assign start  = ld_d & ~ld_n_s;
   assign stop   = ~ld_d & ld_n_s;
   assign active = ~ld_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         ld_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         ld_d   <= ld_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         shreg  <= '0;
         rd_on  <= 1'b0;
         out_sh <= '0;
      end else begin
         if (start) begin
            cnt   <= '0;
            shreg <= '0;
            rd_on <= 1'b0;
         end else if (active && rise) begin
            shreg <= {shreg[FRAME-2:0], sdi_s};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         end else if (active && fall) begin
            if (cnt == CNT_HDR) begin
               rd_on  <= shreg[ADDR_W];
               out_sh <= rdata;
            end else if (cnt > CNT_HDR && cnt < CNT_FRM) begin
               out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            end
         end
         if (stop) rd_on <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmt_vld  <= 1'b0;
         cmt_addr <= '0;
         cmt_data <= '0;
      end else begin
         cmt_vld  <= stop && (cnt == CNT_FRM) && !shreg[FRAME-1];
         cmt_addr <= shreg[FRAME-2 -: ADDR_W];
         cmt_data <= shreg[DATA_W-1:0];
      end
   end

   assign rd_addr = shreg[ADDR_W-1:0];
   assign sdo     = out_sh[DATA_W-1];
   assign sdo_oe  = rd_on & active;

   AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_on) |-> ($past(fall) && $past(cnt) == CNT_HDR)); // R6
   AST_CMT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_vld |-> ($past(cnt) == CNT_FRM && $past(stop))); // R8
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX); // R8
   AST_NO_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop) |-> !sdo_oe); // R6
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
   import ser_ctl_pkg::*;
#(
   parameter int ADDR_W_P = ADDR_W,
   parameter int DATA_W_P = DATA_W,
   parameter int GAIN_W_P = GAIN_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmt_vld,
   input  logic [ADDR_W_P-1:0] cmt_addr,
   input  logic [DATA_W_P-1:0] cmt_data,
   input  logic [ADDR_W_P-1:0] rd_addr,
   output logic [DATA_W_P-1:0] rdata,
   output cfg_t                cfg_q,
   output logic [GAIN_W_P-1:0] gain_q,
   output logic [DATA_W_P-1:0] ofs_q
);
   localparam int GPAD = DATA_W_P - GAIN_W_P;
   localparam int CPAD = DATA_W_P - CFG_W;

   generate
      if (GAIN_W_P >= DATA_W_P) begin : g_bad_gain
         $error("gain field must be narrower than the data word");
      end
      if (CPAD != $bits(CFG_FIXED)) begin : g_bad_cfg
         $error("fixed configuration field width mismatch");
      end
   endgenerate

   logic wr_cfg, wr_gain, wr_ofs;
   assign wr_cfg  = cmt_vld && (cmt_addr == ADR_CFG);
   assign wr_gain = cmt_vld && (cmt_addr == ADR_GAIN);
   assign wr_ofs  = cmt_vld && (cmt_addr == ADR_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RST;
         gain_q <= '0;
         ofs_q  <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= cfg_t'(cmt_data[CFG_W-1:0]);
         if (wr_gain) gain_q <= cmt_data[GAIN_W_P-1:0];
         if (wr_ofs)  ofs_q  <= cmt_data;
      end
   end

   always_comb begin
      unique case (rd_addr)
         ADR_CFG:  rdata = {CFG_FIXED, cfg_q};
         ADR_GAIN: rdata = {{GPAD{1'b0}}, gain_q};
         ADR_OFS:  rdata = ofs_q;
         default:  rdata = '0;
      endcase
   end

   AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmt_vld && cmt_addr == ADR_GAIN) |=> $stable(gain_q)); // R9
   AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmt_vld && cmt_addr == ADR_OFS) |=> $stable(ofs_q)); // R9
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmt_vld && cmt_addr == ADR_CFG) |=> $stable(cfg_q)); // R8
   AST_OFS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_vld && cmt_addr == ADR_OFS) |=> ofs_q == $past(cmt_data)); // R5
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
   import ser_ctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              sclk,
   input  logic              sdio_in,
   output logic              sdio_out,
   output logic              sdio_oe,
   output logic              cds_mode,
   output logic              clamp_hi,
   output logic              pwr_down,
   output logic              out_delay,
   output logic              one_byte,
   output logic [GAIN_W-1:0] gain_code,
   output logic [DATA_W-1:0] offset_sm
);
   logic [2:0] raw_in, syn_in;
   logic [DATA_W-1:0] rdata, cmt_data;
   logic [ADDR_W-1:0] rd_addr, cmt_addr;
   logic cmt_vld;
   cfg_t cfg_q;

   assign raw_in = {ld_n, sclk, sdio_in};

   ser_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

   ser_ctl_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(syn_in[1]), .ld_n_s(syn_in[2]), .sdi_s(syn_in[0]),
      .rdata(rdata), .rd_addr(rd_addr),
      .sdo(sdio_out), .sdo_oe(sdio_oe),
      .cmt_vld(cmt_vld), .cmt_addr(cmt_addr), .cmt_data(cmt_data));

   ser_ctl_regs #(.ADDR_W_P(ADDR_W), .DATA_W_P(DATA_W), .GAIN_W_P(GAIN_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cmt_vld(cmt_vld), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
      .rd_addr(rd_addr), .rdata(rdata),
      .cfg_q(cfg_q), .gain_q(gain_code), .ofs_q(offset_sm));

   assign cds_mode  = cfg_q.cds;
   assign clamp_hi  = cfg_q.clamp_hi;
   assign pwr_down  = cfg_q.pwr_down;
   assign out_delay = cfg_q.out_dly;
   assign one_byte  = cfg_q.one_byte;

   AST_RST_DEFAULT: assert property (@(posedge clk)
      $rose(rst_n) |-> (cds_mode && clamp_hi && !pwr_down && gain_code == '0
                        && offset_sm == '0)); // R1
   AST_OE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> !$past(ld_n, SYNC_STAGES)); // R6
endmodule

// File: tb/tb_ser_ctl_port.sv
module tb_ser_ctl_port;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
   logic sdio_out, sdio_oe;
   logic cds_mode, clamp_hi, pwr_down, out_delay, one_byte;
   logic [5:0] gain_code;
   logic [8:0] offset_sm;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [4:0] m_cfg;
   logic [5:0] m_gain;
   logic [8:0] m_ofs;

   always #4 clk = ~clk;

   ser_ctl_port dut (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .sclk(sclk), .sdio_in(sdio_in),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe),
      .cds_mode(cds_mode), .clamp_hi(clamp_hi), .pwr_down(pwr_down),
      .out_delay(out_delay), .one_byte(one_byte),
      .gain_code(gain_code), .offset_sm(offset_sm));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0:    return {4'b0011, m_cfg};
         3'd3:    return {3'b000, m_gain};
         3'd6:    return m_ofs;
         default: return 9'd0;
      endcase
   endfunction

   task automatic check_ports(input string req);
      check(req, {cds_mode, clamp_hi, pwr_down, out_delay, one_byte}, m_cfg);
      check(req, gain_code, m_gain);
      check(req, offset_sm, m_ofs);
   endtask

   // nbits rising edges; bits beyond 13 are zero
   task automatic xfer(input logic rd, input logic [2:0] a, input logic [8:0] d,
                       input int nbits, output logic [8:0] got, output bit oe_ok);
      logic [12:0] word;
      word = {rd, a, d};
      got = '0;
      oe_ok = 1'b1;
      @(negedge clk);
      ld_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdio_in = (i < 13) ? word[12-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i >= 4 && i < 13 && rd) got = {got[7:0], sdio_out};
         if (sdio_oe !== (rd && i >= 4)) oe_ok = 1'b0;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      ld_n = 1'b1;
      repeat (HALF) @(negedge clk);
      if (sdio_oe !== 1'b0) oe_ok = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [8:0] d);
      logic [8:0] g;
      bit ok;
      xfer(1'b0, a, d, 13, g, ok);
      check("R6 oe low in write", ok, 1'b1);
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a);
      logic [8:0] g;
      bit ok;
      xfer(1'b1, a, 9'd0, 13, g, ok);
      check(req, g, exp_read(a));
      check("R6 oe window", ok, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [8:0] g;
      bit ok;
      m_cfg = 5'b11000;
      m_gain = '0;
      m_ofs = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_ports("R1 reset defaults");
      check("R6 oe idle", sdio_oe, 1'b0);
      rd_chk("R1 R7 reset readback cfg", 3'd0);

      // R4: full gain sweep
      for (int v = 0; v < 64; v++) begin
         wr(3'd3, 9'(v));
         m_gain = 6'(v);
         check_ports("R4 gain ports");
         rd_chk("R4 R2 gain readback", 3'd3);
      end

      // R3: all configuration combinations
      for (int v = 0; v < 32; v++) begin
         wr(3'd0, 9'(v));
         m_cfg = 5'(v);
         check_ports("R3 cfg ports");
         rd_chk("R3 R6 cfg readback", 3'd0);
      end

      // R5: offset stride plus edges
      for (int v = 0; v < 520; v += 7) begin
         logic [8:0] o;
         o = (v > 511) ? 9'd511 : 9'(v);
         wr(3'd6, o);
         m_ofs = o;
         check_ports("R5 offset ports");
         rd_chk("R5 offset readback", 3'd6);
      end
      wr(3'd6, 9'h100); m_ofs = 9'h100;
      check_ports("R5 negative zero");
      wr(3'd6, 9'h0FF); m_ofs = 9'h0FF;
      check_ports("R5 max positive");

      // R7: fixed bits ignored
      wr(3'd0, 9'h1E5); m_cfg = 5'h05;
      check_ports("R7 cfg fixed bits");
      rd_chk("R7 cfg fixed readback", 3'd0);
      wr(3'd3, 9'h1FF); m_gain = 6'h3F;
      rd_chk("R7 gain fixed readback", 3'd3);

      // R8: short and long frames
      xfer(1'b0, 3'd3, 9'h015, 12, g, ok);
      check_ports("R8 short frame gain");
      rd_chk("R8 short frame readback", 3'd3);
      xfer(1'b0, 3'd6, 9'h0AA, 14, g, ok);
      check_ports("R8 long frame offset");
      xfer(1'b0, 3'd0, 9'h000, 4, g, ok);
      check_ports("R8 header only");
      rd_chk("R8 cfg after bad frames", 3'd0);

      // R9: reserved addresses
      for (int a = 0; a < 8; a++) begin
         if (a != 0 && a != 3 && a != 6) begin
            wr(3'(a), 9'h1FF);
            check_ports("R9 reserved write");
            rd_chk("R9 reserved read zero", 3'(a));
         end
      end
      rd_chk("R9 R2 offset intact", 3'd6);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule